// File: doc/BRIEF.md
# Register-Immediate Branch Resolver

This unit resolves the sign-test conditional branches of a 32-bit core that uses one delay slot after each branch. Each cycle in which an instruction issues, the core presents the instruction word, the program counter of that instruction and the value read from its source register. When the word belongs to the register-immediate branch class, the unit decodes the sub-operation and tests the sign bit of the register. It forms the target and the return address, and it keeps the outcome in a small sequencer until the next instruction issues.

That next instruction is the delay slot. The unit tells the core whether the slot executes as a slot or must be squashed. When the branch is taken, the unit raises a redirect with the target while the slot issues, so fetch moves only after the slot. The link forms request a write of the return address to register 31 in the cycle after the branch. An undefined sub-operation raises a one-cycle reserved-instruction pulse and has no other effect.

Top module: `regimm_branch_unit`

## Requirements
- R1: Only words whose bits 31:26 equal 000001 are handled. Any other word produces no link write, no reserved pulse, no slot flag, no nullify and no redirect.
- R2: Bits 20:16 of the word select the operation. 0x00 tests negative, 0x01 tests non-negative, 0x02 and 0x03 are the likely forms of those two, and 0x10 and 0x11 are the linking forms of those two.
- R3: Any other value of bits 20:16 raises `rsvd_o` for exactly one cycle, in the cycle after issue. While it is high, `link_we_o`, `slot_o`, `nullify_o` and `redirect_o` stay low.
- R4: The branch condition uses only bit 31 of `rs_val_i` as presented in the issue cycle. Negative means that bit is 1, and non-negative means it is 0.
- R5: The target is `pc_i` + 4 plus the 16-bit field in bits 15:0, sign-extended and multiplied by 4. The sum wraps modulo 2^32.
- R6: For the non-likely forms, the next issued instruction sees `slot_o`=1. `redirect_o`=1 with `redirect_pc_o`=target is raised in that same cycle only when the branch is taken.
- R7: For a taken likely form, the next issued instruction sees `slot_o`=1 and `redirect_o`=1. For a not-taken likely form, it sees `nullify_o`=1, `slot_o`=0 and `redirect_o`=0.
- R8: The linking forms raise `link_we_o` for one cycle in the cycle after issue, with `link_idx_o`=31 and `link_data_o`=`pc_i`+8, whether or not the branch is taken.
- R9: A resolved branch stays pending across cycles with `issue_valid_i`=0 and is consumed by the next issued instruction. The instruction after that sees no slot, nullify or redirect.
- R10: A word issued as a delay slot is never decoded as a branch, even if it is one. It causes no link write, no reserved pulse and no pending branch.
- R11: A synchronous reset clears the pending branch and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid_i | input | 1 | An instruction issues this cycle |
| instr_i | input | 32 | Issued instruction word |
| pc_i | input | 32 | Address of the issued instruction |
| rs_val_i | input | 32 | Source register value for the issued instruction |
| link_we_o | output | 1 | Return-address write request |
| link_idx_o | output | 5 | Register index for the link write (31) |
| link_data_o | output | 32 | Return address (branch pc + 8) |
| slot_o | output | 1 | Issued instruction executes as a delay slot |
| nullify_o | output | 1 | Issued instruction must be squashed |
| redirect_o | output | 1 | Fetch must move to `redirect_pc_o` |
| redirect_pc_o | output | 32 | Branch target |
| rsvd_o | output | 1 | Reserved-instruction pulse |

## Verification
The hardest case to reach is a delay slot that is itself a branch-class word, or one that arrives only after idle cycles while a branch is pending. The sequencer has to keep its outcome through the gap and then consume the slot word without decoding it. The directed tasks set up these cases by holding `issue_valid_i` low for several cycles after a branch. They then issue a linking branch word, or an undefined one, as the slot. The checks confirm that only the first branch's outcome appears and that no link or reserved pulse follows.

// File: rtl/regimm_pkg.sv
package regimm_pkg;

    // Opcode of the register-immediate class (bits 31:26).
    localparam logic [5:0] REGIMM_OPC = 6'b000001;

    // Sub-operation codes in bits 20:16.
    localparam logic [4:0] SUB_LTZ   = 5'h00;
    localparam logic [4:0] SUB_GEZ   = 5'h01;
    localparam logic [4:0] SUB_LTZL  = 5'h02;
    localparam logic [4:0] SUB_GEZL  = 5'h03;
    localparam logic [4:0] SUB_LTZAL = 5'h10;
    localparam logic [4:0] SUB_GEZAL = 5'h11;

    typedef enum logic [2:0] {
        BR_NONE,
        BR_LTZ,
        BR_GEZ,
        BR_LTZL,
        BR_GEZL,
        BR_LTZAL,
        BR_GEZAL,
        BR_BAD
    } br_kind_e;

    // Decoded attributes of one issued word.
    typedef struct packed {
        logic hit;      // valid branch of this class
        logic bad;      // class opcode with undefined sub-operation
        logic taken;    // condition result
        logic likely;   // squash slot when not taken
        logic link;     // writes return address
    } br_dec_t;

endpackage

// File: rtl/regimm_decoder.sv
module regimm_decoder
    import regimm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    output br_dec_t         dec_o
);

    logic       opc_match;
    logic [4:0] sub;
    br_kind_e   kind;
    logic       neg;

    assign opc_match = (instr_i[31:26] == REGIMM_OPC);
    assign sub       = instr_i[20:16];
    assign neg       = rs_val_i[XLEN-1];

    always_comb begin
        kind = BR_NONE;
        if (opc_match) begin
            unique case (sub)
                SUB_LTZ:   kind = BR_LTZ;
                SUB_GEZ:   kind = BR_GEZ;
                SUB_LTZL:  kind = BR_LTZL;
                SUB_GEZL:  kind = BR_GEZL;
                SUB_LTZAL: kind = BR_LTZAL;
                SUB_GEZAL: kind = BR_GEZAL;
                default:   kind = BR_BAD;
            endcase
        end
    end

    always_comb begin
        dec_o = '0;
        unique case (kind)
            BR_LTZ: begin
                dec_o.hit   = 1'b1;
                dec_o.taken = neg;
            end
            BR_GEZ: begin
                dec_o.hit   = 1'b1;
                dec_o.taken = ~neg;
            end
            BR_LTZL: begin
                dec_o.hit    = 1'b1;
                dec_o.likely = 1'b1;
                dec_o.taken  = neg;
            end
            BR_GEZL: begin
                dec_o.hit    = 1'b1;
                dec_o.likely = 1'b1;
                dec_o.taken  = ~neg;
            end
            BR_LTZAL: begin
                dec_o.hit   = 1'b1;
                dec_o.link  = 1'b1;
                dec_o.taken = neg;
            end
            BR_GEZAL: begin
                dec_o.hit   = 1'b1;
                dec_o.link  = 1'b1;
                dec_o.taken = ~neg;
            end
            BR_BAD:  dec_o.bad = 1'b1;
            default: dec_o = '0;
        endcase
    end

endmodule

// File: rtl/regimm_addr_gen.sv
module regimm_addr_gen #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [XLEN-1:0]  target_o,
    output logic [XLEN-1:0]  link_o
);

    localparam int SHIFT   = 2;
    localparam int EXT_W   = XLEN - OFF_W - SHIFT;
    localparam int INSN_SZ = 4;

    logic [XLEN-1:0] slot_pc;
    logic [XLEN-1:0] byte_off;

    assign slot_pc  = pc_i + XLEN'(INSN_SZ);
    assign byte_off = {{EXT_W{off_i[OFF_W-1]}}, off_i, {SHIFT{1'b0}}};
    assign target_o = slot_pc + byte_off;
    assign link_o   = slot_pc + XLEN'(INSN_SZ);

endmodule

// File: rtl/regimm_slot_seq.sv
module regimm_slot_seq
    import regimm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid_i,
    input  br_dec_t         dec_i,
    input  logic [XLEN-1:0] target_i,
    input  logic [XLEN-1:0] link_i,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_data_o,
    output logic            slot_o,
    output logic            nullify_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            rsvd_o
);

    typedef struct packed {
        logic            pend;
        logic            taken;
        logic            squash;
        logic [XLEN-1:0] target;
        logic            link_we;
        logic [XLEN-1:0] link_data;
        logic            rsvd;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       slot_use;

    assign slot_use = s_q.pend & issue_valid_i;

    always_comb begin
        s_d         = s_q;
        s_d.link_we = 1'b0;
        s_d.rsvd    = 1'b0;
        if (slot_use) begin
            s_d.pend = 1'b0;
        end else if (issue_valid_i) begin
            if (dec_i.bad) begin
                s_d.rsvd = 1'b1;
            end else if (dec_i.hit) begin
                s_d.pend      = 1'b1;
                s_d.taken     = dec_i.taken;
                s_d.squash    = dec_i.likely & ~dec_i.taken;
                s_d.target    = target_i;
                s_d.link_we   = dec_i.link;
                s_d.link_data = link_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign link_we_o     = s_q.link_we;
    assign link_data_o   = s_q.link_data;
    assign rsvd_o        = s_q.rsvd;
    assign slot_o        = slot_use & ~s_q.squash;
    assign nullify_o     = slot_use & s_q.squash;
    assign redirect_o    = slot_use & s_q.taken;
    assign redirect_pc_o = s_q.target;

endmodule

// File: rtl/regimm_branch_unit.sv
module regimm_branch_unit
    import regimm_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 16,
    parameter int LINK_REG = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] rs_val_i,
    output logic            link_we_o,
    output logic [4:0]      link_idx_o,
    output logic [XLEN-1:0] link_data_o,
    output logic            slot_o,
    output logic            nullify_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            rsvd_o
);

    br_dec_t         dec;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] link_addr;

    regimm_decoder #(.XLEN(XLEN)) dec_i (
        .instr_i  (instr_i),
        .rs_val_i (rs_val_i),
        .dec_o    (dec)
    );

    regimm_addr_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) agen_i (
        .pc_i     (pc_i),
        .off_i    (instr_i[OFF_W-1:0]),
        .target_o (target),
        .link_o   (link_addr)
    );

    regimm_slot_seq #(.XLEN(XLEN)) seq_i (
        .clk           (clk),
        .rst           (rst),
        .issue_valid_i (issue_valid_i),
        .dec_i         (dec),
        .target_i      (target),
        .link_i        (link_addr),
        .link_we_o     (link_we_o),
        .link_data_o   (link_data_o),
        .slot_o        (slot_o),
        .nullify_o     (nullify_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .rsvd_o        (rsvd_o)
    );

    assign link_idx_o = 5'(LINK_REG);

endmodule

// File: rtl/regimm_branch_unit_chk.sv
module regimm_branch_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_valid_i,
    input logic [XLEN-1:0] pc_i,
    input logic            link_we_o,
    input logic [4:0]      link_idx_o,
    input logic [XLEN-1:0] link_data_o,
    input logic            slot_o,
    input logic            nullify_o,
    input logic            redirect_o,
    input logic            rsvd_o
);

    // R3
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsvd_o |-> !link_we_o && !slot_o && !nullify_o && !redirect_o);

    // R6
    redirect_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> slot_o);

    // R7
    slot_or_squash_chk: assert property (@(posedge clk) disable iff (rst)
        !(slot_o && nullify_o));

    // R8
    link_data_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_data_o == $past(pc_i) + XLEN'(8)) && (link_idx_o == 5'd31));

    // R9
    slot_needs_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_o || nullify_o) |-> issue_valid_i);

    // R10
    slot_not_decoded_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_o || nullify_o) |=> !link_we_o && !rsvd_o);

endmodule

bind regimm_branch_unit regimm_branch_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .issue_valid_i (issue_valid_i),
    .pc_i          (pc_i),
    .link_we_o     (link_we_o),
    .link_idx_o    (link_idx_o),
    .link_data_o   (link_data_o),
    .slot_o        (slot_o),
    .nullify_o     (nullify_o),
    .redirect_o    (redirect_o),
    .rsvd_o        (rsvd_o)
);

// File: tb/regimm_branch_unit_tb_top.sv
module regimm_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid_i;
    logic [31:0] instr_i;
    logic [31:0] pc_i;
    logic [31:0] rs_val_i;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_data_o;
    logic        slot_o;
    logic        nullify_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic        rsvd_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    regimm_branch_unit dut_i (
        .clk           (clk),
        .rst           (rst),
        .issue_valid_i (issue_valid_i),
        .instr_i       (instr_i),
        .pc_i          (pc_i),
        .rs_val_i      (rs_val_i),
        .link_we_o     (link_we_o),
        .link_idx_o    (link_idx_o),
        .link_data_o   (link_data_o),
        .slot_o        (slot_o),
        .nullify_o     (nullify_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .rsvd_o        (rsvd_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] sub,
                                       input logic [15:0] off);
        return {opc, 5'd7, sub, off};
    endfunction

    task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] p,
                         input logic [31:0] r);
        issue_valid_i = v;
        instr_i       = w;
        pc_i          = p;
        rs_val_i      = r;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reports the four slot-side outputs of the current cycle against expectations.
    task automatic check_slot(input string tag, input bit e_slot, input bit e_null,
                              input bit e_redir, input logic [31:0] e_tgt);
        #1;
        check(slot_o == e_slot, {tag, " slot"}, 32'(slot_o), 32'(e_slot));
        check(nullify_o == e_null, {tag, " nullify"}, 32'(nullify_o), 32'(e_null));
        check(redirect_o == e_redir, {tag, " redirect"}, 32'(redirect_o), 32'(e_redir));
        if (e_redir)
            check(redirect_pc_o == e_tgt, {tag, " target"}, redirect_pc_o, e_tgt);
    endtask

    // R2 R4 R5 R6 R7 R8 R9: issue one branch, optional idle gap, slot, then follower.
    task automatic run_branch(input string tag, input logic [4:0] sub,
                              input logic [15:0] off, input logic [31:0] p,
                              input logic [31:0] r, input int gap,
                              input logic [31:0] slot_word);
        bit          likely = (sub == 5'h02) || (sub == 5'h03);
        bit          link   = sub[4];
        bit          tk     = sub[0] ? ~r[31] : r[31];
        logic [31:0] tgt    = p + 32'd4 + {{14{off[15]}}, off, 2'b00};
        drive(1'b1, mk(6'b000001, sub, off), p, r);
        step();
        check(link_we_o == link, {tag, " R8 link_we"}, 32'(link_we_o), 32'(link));
        if (link) begin
            check(link_data_o == p + 32'd8, {tag, " R8 link_data"}, link_data_o, p + 32'd8);
            check(link_idx_o == 5'd31, {tag, " R8 link_idx"}, 32'(link_idx_o), 32'd31);
        end
        check(rsvd_o == 1'b0, {tag, " R3 rsvd"}, 32'(rsvd_o), 32'd0);
        for (int i = 0; i < gap; i++) begin
            drive(1'b0, 32'h0, 32'h0, 32'h0);
            check_slot({tag, " R9 gap"}, 1'b0, 1'b0, 1'b0, 32'h0);
            step();
            check(link_we_o == 1'b0, {tag, " R8 one pulse"}, 32'(link_we_o), 32'd0);
        end
        drive(1'b1, slot_word, p + 32'd4, 32'h8000_0000);
        check_slot({tag, " R6 R7 slot"}, !likely || tk, likely && !tk, tk, tgt);
        step();
        check(link_we_o == 1'b0, {tag, " R10 no link"}, 32'(link_we_o), 32'd0);
        check(rsvd_o == 1'b0, {tag, " R10 no rsvd"}, 32'(rsvd_o), 32'd0);
        drive(1'b1, 32'h0, p + 32'd8, 32'h0);
        check_slot({tag, " R9 consumed"}, 1'b0, 1'b0, 1'b0, 32'h0);
        step();
        drive(1'b0, 32'h0, 32'h0, 32'h0);
    endtask

    // R3: undefined sub-operation.
    task automatic run_reserved(input logic [4:0] sub);
        drive(1'b1, mk(6'b000001, sub, 16'h0010), 32'h0000_2000, 32'hFFFF_FFFF);
        step();
        drive(1'b1, 32'h0, 32'h0000_2004, 32'h0);
        #1;
        check(rsvd_o == 1'b1, "R3 rsvd pulse", 32'(rsvd_o), 32'd1);
        check(link_we_o == 1'b0, "R3 no link", 32'(link_we_o), 32'd0);
        check_slot("R3 no slot", 1'b0, 1'b0, 1'b0, 32'h0);
        step();
        drive(1'b0, 32'h0, 32'h0, 32'h0);
        check(rsvd_o == 1'b0, "R3 one cycle", 32'(rsvd_o), 32'd0);
        check_slot("R3 nothing pending", 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    // R1: other opcodes are ignored.
    task automatic run_other_opcode();
        drive(1'b1, mk(6'b000100, 5'h10, 16'h0004), 32'h0000_3000, 32'hFFFF_FFFF);
        step();
        drive(1'b1, 32'h0, 32'h0000_3004, 32'h0);
        check(link_we_o == 1'b0, "R1 no link", 32'(link_we_o), 32'd0);
        check(rsvd_o == 1'b0, "R1 no rsvd", 32'(rsvd_o), 32'd0);
        check_slot("R1 no slot", 1'b0, 1'b0, 1'b0, 32'h0);
        step();
        drive(1'b0, 32'h0, 32'h0, 32'h0);
    endtask

    // R11: reset while a branch is pending.
    task automatic run_reset_pending();
        drive(1'b1, mk(6'b000001, 5'h00, 16'h0008), 32'h0000_5000, 32'h8000_0000);
        step();
        drive(1'b0, 32'h0, 32'h0, 32'h0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        drive(1'b1, 32'h0, 32'h0000_5004, 32'h0);
        check_slot("R11 pending cleared", 1'b0, 1'b0, 1'b0, 32'h0);
        step();
        drive(1'b0, 32'h0, 32'h0, 32'h0);
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 32'h0, 32'h0, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(link_we_o == 1'b0, "R11 reset link_we", 32'(link_we_o), 32'd0);
        check(rsvd_o == 1'b0, "R11 reset rsvd", 32'(rsvd_o), 32'd0);
        check({slot_o, nullify_o, redirect_o} == 3'b000, "R11 reset slot outputs",
              32'({slot_o, nullify_o, redirect_o}), 32'd0);
        @(negedge clk);

        run_branch("R2 ltz taken",        5'h00, 16'h0010, 32'h0000_1000, 32'h8000_0001, 0, 32'h0);
        run_branch("R2 ltz not",          5'h00, 16'h0010, 32'h0000_1000, 32'h7FFF_FFFF, 0, 32'h0);
        run_branch("R4 gez zero taken",   5'h01, 16'hFFF0, 32'h0000_1000, 32'h0000_0000, 0, 32'h0);
        run_branch("R4 gez not",          5'h01, 16'h0020, 32'h0000_1100, 32'hFFFF_FFFF, 0, 32'h0);
        run_branch("R7 ltzl taken",       5'h02, 16'h0003, 32'h0000_1200, 32'h8000_0000, 0, 32'h0);
        run_branch("R7 ltzl squash",      5'h02, 16'h0003, 32'h0000_1200, 32'h0000_0005, 0, 32'h0);
        run_branch("R7 gezl taken",       5'h03, 16'h8000, 32'h0004_0000, 32'h0000_0001, 0, 32'h0);
        run_branch("R7 gezl squash",      5'h03, 16'h8000, 32'h0004_0000, 32'hC000_0000, 0, 32'h0);
        run_branch("R8 ltzal taken",      5'h10, 16'h0040, 32'h0000_2000, 32'hF000_0000, 0, 32'h0);
        run_branch("R8 ltzal not",        5'h10, 16'h0040, 32'h0000_2000, 32'h0000_0010, 0, 32'h0);
        run_branch("R8 gezal taken",      5'h11, 16'hFFFF, 32'h0000_2100, 32'h0000_0000, 0, 32'h0);
        run_branch("R8 gezal not",        5'h11, 16'hFFFF, 32'h0000_2100, 32'h8000_0000, 0, 32'h0);
        run_branch("R5 wrap high",        5'h01, 16'h7FFF, 32'hFFFF_FFF8, 32'h0000_0001, 0, 32'h0);
        run_branch("R5 wrap low",         5'h00, 16'h8000, 32'h0000_0010, 32'h8000_0000, 0, 32'h0);
        run_branch("R9 gap taken",        5'h00, 16'h0100, 32'h0000_6000, 32'h8000_0000, 3, 32'h0);
        run_branch("R10 link word slot",  5'h11, 16'h0004, 32'h0000_7000, 32'h0000_0000, 2,
                   mk(6'b000001, 5'h10, 16'h0100));
        run_branch("R10 bad word slot",   5'h02, 16'h0004, 32'h0000_7100, 32'h0000_0001, 0,
                   mk(6'b000001, 5'h1F, 16'h0000));

        run_reserved(5'h04);
        run_reserved(5'h12);
        run_reserved(5'h1F);
        run_other_opcode();
        run_reset_pending();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R9 actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule